// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a pipelined synchronous SRAM with burst addressing. The memory array has a configurable number of words, and each word is made of four byte lanes. Every control, address and data input is captured on the rising clock edge. A cycle can be opened by either of two address strobes. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls sampled with it.

Once a cycle is open, a 2-bit beat counter supplies the two lowest address bits. The counter steps when the advance input is low. When the advance input is high, the counter holds and the same word is accessed again. The step order is either linear or interleaved, chosen by a mode input. Writes are selected per byte lane, or for all lanes at once through a global-write input.

Reads are pipelined: the data is valid after the second rising edge that follows the address. The read value is presented as a data bus plus an enable flag rather than as a tristate pin. That flag follows an asynchronous, active-low output enable. After a deselect, the flag falls one cycle later.

Top module: `sync_burst_sram`

## Requirements
- R1: Every synchronous input is sampled on the rising edge of `clk`. While `rst_n` is low and right after reset, `dout_en` is 0. Read data for an access captured at edge N is on `dout` after edge N+1.
- R2: When `ads_proc_n`=0 and `ce_n`=0 at an edge, the address on `addr` is loaded and a read of that word starts if `ce2`=1 and `ce3_n`=0. Otherwise the block is deselected.
- R3: On a cycle started by `ads_proc_n`, the write controls (`gw_n`, `bwe_n`, `bw_n`) are ignored and the array is left unchanged.
- R4: While `ce_n`=1, a low `ads_proc_n` has no effect: a burst already in progress continues with its own address sequence.
- R5: When `ads_ctrl_n`=0 (and the processor path is not starting), `addr` is loaded and the enables are sampled. The block is selected only when `ce_n`=0, `ce2`=1 and `ce3_n`=0. When selected, it writes if any byte enable is active and reads otherwise.
- R6: During an open cycle without a strobe, `adv_n`=0 steps the beat counter by one. `adv_n`=1 is a wait cycle that repeats the current word.
- R7: With `mode`=0, the low two address bits are (start + beat) mod 4. With `mode`=1, they are start XOR beat. Above the low two bits, the address stays at the loaded value, so a burst longer than four beats wraps within its aligned 4-word block.
- R8: When `gw_n`=0, all four byte lanes are written, whatever the values of `bwe_n` and `bw_n`.
- R9: When `gw_n`=1 and `bwe_n`=0, bit i of `bw_n` (active low) writes lane i. Lane i is `din[8i+7:8i]`, so bit 0 is the lowest byte. When `bwe_n`=1, `bw_n` writes nothing.
- R10: `dout_en` is 1 only while `oe_n`=0, and it follows `oe_n` with no clock edge in between.
- R11: After a deselect is captured at edge N, `dout_en` is 0 from edge N+1. Read data of the access before the deselect is still shown up to edge N+1.
- R12: If both strobes are low at the same edge with `ce_n`=0, the processor strobe wins: a read starts, and no write happens.
- R13: A write captured at edge N is visible to a read of the same word captured at edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr | input | ADDR_W | Word address |
| din | input | 32 | Write data, four byte lanes |
| ce_n | input | 1 | Active-low enable, also gates the processor strobe |
| ce2 | input | 1 | Active-high depth enable |
| ce3_n | input | 1 | Active-low depth enable |
| ads_proc_n | input | 1 | Processor address strobe, read only |
| ads_ctrl_n | input | 1 | Controller address strobe, read or write |
| adv_n | input | 1 | Burst advance, high = wait |
| bw_n | input | 4 | Per-lane byte write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 32 | Read data, zero when not enabled |
| dout_en | output | 1 | High while `dout` carries valid read data |

## Verification
The block's hidden state is the open-cycle flag, the loaded base address and the beat counter. A fault in any of these shows up as a wrong word on `dout` two edges after the faulty access. A wrongly stepped or held counter corrupts every later beat of the burst. A stale open-cycle flag shows as `dout_en` staying high one cycle past a deselect. Byte-decode faults are invisible at write time and show up only when the word is read back. The sweeps therefore read back every word that was written, and they cover every lane pattern, every start offset and both orders.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;

  // low two address bits for a given start offset and beat number
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input burst_ord_e ord);
    if (ord == ORD_INTERLEAVE) return start ^ beat;
    return start + beat;
  endfunction

  // lane enables from the write controls
  function automatic logic [3:0] lane_enables(input logic gw_n,
                                              input logic bwe_n,
                                              input logic [3:0] bw_n);
    if (!gw_n) return 4'hF;
    if (!bwe_n) return ~bw_n;
    return 4'h0;
  endfunction

endpackage

// File: rtl/sbs_wdec.sv
module sbs_wdec
  import sbs_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          gw_n_i,
  input  logic          bwe_n_i,
  input  logic [NB-1:0] bw_n_i,
  output logic [NB-1:0] be_o,
  output logic          wr_req_o
);

  generate
    if (NB == 4) begin : g_four
      always_comb be_o = lane_enables(gw_n_i, bwe_n_i, bw_n_i);
    end else begin : g_any
      always_comb begin
        if (!gw_n_i)       be_o = '1;
        else if (!bwe_n_i) be_o = ~bw_n_i;
        else               be_o = '0;
      end
    end
  endgenerate

  assign wr_req_o = |be_o;

endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  input  logic [NB-1:0] be_i,
  input  logic          wr_req_i,
  input  logic          ce_n_i,
  input  logic          ce2_i,
  input  logic          ce3_n_i,
  input  logic          ads_proc_n_i,
  input  logic          ads_ctrl_n_i,
  input  logic          adv_n_i,
  input  logic          mode_i,
  output logic          acc_valid_o,
  output logic          acc_write_o,
  output logic [AW-1:0] acc_addr_o,
  output logic [NB-1:0] acc_be_o,
  output logic [DW-1:0] acc_data_o
);

  logic          active_q;
  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;

  // named internal events
  logic          enables_ok;
  logic          proc_start;
  logic          ctrl_start;
  logic          any_start;
  logic          burst_adv;
  logic [1:0]    beat_nx;
  logic [AW-1:0] cont_addr;
  logic          issue_valid;
  logic          issue_write;
  logic [AW-1:0] issue_addr;

  assign enables_ok = !ce_n_i && ce2_i && !ce3_n_i;
  assign proc_start = !ads_proc_n_i && !ce_n_i;
  assign ctrl_start = !ads_ctrl_n_i && !proc_start;
  assign any_start  = proc_start || ctrl_start;
  assign burst_adv  = !any_start && active_q && !adv_n_i;
  assign beat_nx    = burst_adv ? beat_q + 2'd1 : beat_q;
  assign cont_addr  = {base_q[AW-1:2],
                       burst_lo(base_q[1:0], beat_nx, burst_ord_e'(mode_i))};

  assign issue_valid = any_start ? enables_ok : active_q;
  assign issue_write = issue_valid && wr_req_i && !proc_start;
  assign issue_addr  = any_start ? addr_i : cont_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
    end else if (any_start) begin
      active_q <= enables_ok;
      base_q   <= addr_i;
      beat_q   <= '0;
    end else begin
      beat_q   <= beat_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid_o <= 1'b0;
      acc_write_o <= 1'b0;
      acc_addr_o  <= '0;
      acc_be_o    <= '0;
      acc_data_o  <= '0;
    end else begin
      acc_valid_o <= issue_valid;
      acc_write_o <= issue_write;
      acc_addr_o  <= issue_addr;
      acc_be_o    <= be_i;
      acc_data_o  <= din_i;
    end
  end

  assert_proc_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    proc_start |=> !acc_write_o);

  assert_ce_blocks_proc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_proc_n_i && ce_n_i && ads_ctrl_n_i && !active_q) |=> !acc_valid_o);

  assert_wait_repeats_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_start && active_q && adv_n_i) |=> $stable(acc_addr_o));

  assert_burst_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_start && active_q) |=> (acc_addr_o[AW-1:2] == $past(base_q[AW-1:2])));

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int DW    = NB * BW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid_i,
  input  logic          acc_write_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [NB-1:0] acc_be_i,
  input  logic [DW-1:0] acc_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);

  logic rd_fire;
  logic wr_fire;

  assign rd_fire = acc_valid_i && !acc_write_i;
  assign wr_fire = acc_valid_i && acc_write_i;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] lane_mem [DEPTH];
    logic [BW-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_fire && acc_be_i[g]) lane_mem[acc_addr_i] <= acc_data_i[g*BW +: BW];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       lane_q <= '0;
      else if (rd_fire) lane_q <= lane_mem[acc_addr_i];
    end

    assign rd_data_o[g*BW +: BW] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid_o <= 1'b0;
    else        rd_valid_o <= rd_fire;
  end

  assert_deselect_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |=> !rd_valid_o);

  assert_write_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !rd_valid_o);

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     din,
  input  logic              ce_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              adv_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              bwe_n,
  input  logic              gw_n,
  input  logic              mode,
  input  logic              oe_n,
  output logic [DW-1:0]     dout,
  output logic              dout_en
);

  logic [LANES-1:0]  be;
  logic              wr_req;
  logic              acc_valid;
  logic              acc_write;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_be;
  logic [DW-1:0]     acc_data;
  logic [DW-1:0]     rd_data;
  logic              rd_valid;

  sbs_wdec #(.NB(LANES)) wdec_i (
    .gw_n_i   (gw_n),
    .bwe_n_i  (bwe_n),
    .bw_n_i   (bw_n),
    .be_o     (be),
    .wr_req_o (wr_req)
  );

  sbs_ctrl #(.AW(ADDR_W), .NB(LANES), .BW(LANE_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr),
    .din_i        (din),
    .be_i         (be),
    .wr_req_i     (wr_req),
    .ce_n_i       (ce_n),
    .ce2_i        (ce2),
    .ce3_n_i      (ce3_n),
    .ads_proc_n_i (ads_proc_n),
    .ads_ctrl_n_i (ads_ctrl_n),
    .adv_n_i      (adv_n),
    .mode_i       (mode),
    .acc_valid_o  (acc_valid),
    .acc_write_o  (acc_write),
    .acc_addr_o   (acc_addr),
    .acc_be_o     (acc_be),
    .acc_data_o   (acc_data)
  );

  sbs_array #(.AW(ADDR_W), .NB(LANES), .BW(LANE_W)) array_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid_i (acc_valid),
    .acc_write_i (acc_write),
    .acc_addr_i  (acc_addr),
    .acc_be_i    (acc_be),
    .acc_data_i  (acc_data),
    .rd_data_o   (rd_data),
    .rd_valid_o  (rd_valid)
  );

  assign dout_en = rd_valid && !oe_n;
  assign dout    = dout_en ? rd_data : '0;

  assert_global_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gw_n |-> (be == '1));

  assert_bwe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && bwe_n) |-> !wr_req);

  assert_pipeline_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !oe_n) |=> (oe_n || dout_en));

endmodule

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;

  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [31:0]   din;
  logic          ce_n, ce2, ce3_n, ads_proc_n, ads_ctrl_n, adv_n;
  logic [3:0]    bw_n;
  logic          bwe_n, gw_n, mode, oe_n;
  logic [31:0]   dout;
  logic          dout_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .ce2(ce2),
    .ce3_n(ce3_n), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
    .adv_n(adv_n), .bw_n(bw_n), .bwe_n(bwe_n), .gw_n(gw_n), .mode(mode),
    .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  // reference state
  logic [31:0]   ref_mem [NW];
  bit            m_open;
  logic [AW-1:0] m_base;
  int            m_beat;
  bit            s_valid, s_write;
  logic [AW-1:0] s_addr;
  logic [3:0]    s_lanes;
  logic [31:0]   s_data;
  bit            o_valid;
  logic [31:0]   o_data;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ads_proc_n = 1; ads_ctrl_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1;
    bw_n = 4'hF; ce_n = 0; ce2 = 1; ce3_n = 0; oe_n = 0; din = '0;
  endtask

  task automatic model_edge();
    bit sel, pstart, cstart;
    logic [3:0] lanes;
    logic [1:0] lo;
    if (s_valid && s_write)
      for (int l = 0; l < 4; l++)
        if (s_lanes[l]) ref_mem[s_addr][8*l +: 8] = s_data[8*l +: 8];
    o_valid = s_valid && !s_write;
    if (o_valid) o_data = ref_mem[s_addr];
    sel    = (ce_n == 0) && (ce2 == 1) && (ce3_n == 0);
    pstart = (ads_proc_n == 0) && (ce_n == 0);
    cstart = (ads_ctrl_n == 0) && !pstart;
    lanes  = 4'h0;
    if (gw_n == 0) lanes = 4'hF;
    else if (bwe_n == 0) lanes = ~bw_n;
    s_lanes = lanes;
    s_data  = din;
    if (pstart || cstart) begin
      m_open  = sel;
      m_base  = addr;
      m_beat  = 0;
      s_valid = sel;
      s_write = sel && cstart && (lanes != 0);
      s_addr  = addr;
    end else if (m_open) begin
      if (adv_n == 0) m_beat = (m_beat + 1) % 4;
      if (mode) lo = m_base[1:0] ^ 2'(m_beat);
      else      lo = 2'((int'(m_base[1:0]) + m_beat) % 4);
      s_valid = 1;
      s_write = (lanes != 0);
      s_addr  = {m_base[AW-1:2], lo};
    end else begin
      s_valid = 0;
      s_write = 0;
    end
  endtask

  task automatic tick(string req);
    bit exp_en;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    exp_en = o_valid && !oe_n;
    chk(req, {31'd0, dout_en}, {31'd0, exp_en});
    if (exp_en) chk(req, dout, o_data);
  endtask

  task automatic ctrl_write(logic [AW-1:0] a, logic [31:0] d, logic g,
                            logic be, logic [3:0] bw, string req);
    idle(); ads_ctrl_n = 0; addr = a; din = d; gw_n = g; bwe_n = be; bw_n = bw;
    tick(req);
  endtask

  task automatic proc_read(logic [AW-1:0] a, string req);
    idle(); ads_proc_n = 0; addr = a;
    tick(req);
  endtask

  task automatic deselect(string req);
    idle(); ads_ctrl_n = 0; ce2 = 0; tick(req);
    idle(); tick(req);
    idle(); tick(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(); addr = '0; mode = 0; rst_n = 0;
    m_open = 0; m_beat = 0; m_base = '0; s_valid = 0; s_write = 0;
    s_addr = '0; s_lanes = '0; s_data = '0; o_valid = 0; o_data = '0;
    for (int i = 0; i < NW; i++) ref_mem[i] = 'x;
    repeat (3) @(negedge clk);
    chk("R1 reset", {31'd0, dout_en}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {31'd0, dout_en}, 32'd0);

    // fill with global write, byte enables set to block (must not matter)
    for (int a = 0; a < NW; a++)
      ctrl_write(AW'(a), (a * 32'h01030507) ^ 32'hA5A5_0000, 0, 0, 4'hF, "R8");
    deselect("R11");

    // R2: processor-strobe reads across the array, back to back
    for (int a = 0; a < NW; a++) proc_read(AW'(a), "R2");
    deselect("R11");

    // R9: every lane pattern, and bw_n without bwe_n
    for (int p = 0; p < 16; p++) begin
      ctrl_write(AW'(p), 32'h1122_3344 + p * 32'h0101_0101, 1, 0, 4'(p), "R9");
      ctrl_write(AW'(16 + p), 32'hDEAD_BEEF, 1, 1, 4'(p), "R9");
    end
    for (int a = 0; a < 32; a++) proc_read(AW'(a), "R9");

    // R3: write controls on the processor path are ignored
    for (int a = 40; a < 44; a++) begin
      idle(); ads_proc_n = 0; addr = AW'(a); gw_n = 0; din = 32'hFFFF_0000; tick("R3");
    end
    deselect("R3");
    for (int a = 40; a < 44; a++) begin
      idle(); ads_ctrl_n = 0; addr = AW'(a); tick("R3");
    end

    // R4: processor strobe while ce_n high does not reload the burst
    idle(); ads_ctrl_n = 0; addr = AW'(9); tick("R5");
    for (int k = 0; k < 4; k++) begin
      idle(); ads_proc_n = 0; ce_n = 1; addr = AW'(50); adv_n = 0; tick("R4");
    end
    deselect("R11");
    idle(); ads_proc_n = 0; ce_n = 1; addr = AW'(50); tick("R4");
    idle(); tick("R4");

    // R6/R7: bursts in both orders from every start, with waits and wrap
    for (int m = 0; m < 2; m++) begin
      for (int st = 0; st < 4; st++) begin
        mode = m[0];
        idle(); ads_ctrl_n = 0; addr = AW'(24 + st); tick("R7");
        for (int k = 0; k < 7; k++) begin
          idle(); adv_n = (k == 2 || k == 3) ? 1'b1 : 1'b0;
          tick(k == 2 || k == 3 ? "R6" : "R7");
        end
        deselect("R11");
      end
    end
    mode = 0;

    // R5/R11: deselect through each enable
    idle(); ads_ctrl_n = 0; addr = AW'(5); tick("R5");
    idle(); ads_ctrl_n = 0; ce3_n = 1; tick("R11");
    idle(); tick("R11");
    idle(); ads_proc_n = 0; ce2 = 0; addr = AW'(6); tick("R2");
    idle(); tick("R2");
    idle(); ads_ctrl_n = 0; ce_n = 1; addr = AW'(7); gw_n = 0; tick("R5");
    idle(); tick("R5");
    proc_read(AW'(7), "R5");

    // R13: write then immediate read of the same word
    for (int a = 48; a < 56; a++) begin
      ctrl_write(AW'(a), 32'h5A00_0000 + a, 0, 1, 4'hF, "R13");
      proc_read(AW'(a), "R13");
      ctrl_write(AW'(a), 32'h00C3_0000 + a, 1, 0, 4'b1011, "R13");
      proc_read(AW'(a), "R13");
    end

    // R12: both strobes together: read, no write
    for (int a = 56; a < 60; a++) begin
      idle(); ads_proc_n = 0; ads_ctrl_n = 0; gw_n = 0; addr = AW'(a);
      din = 32'h0BAD_0BAD; tick("R12");
    end
    for (int a = 56; a < 60; a++) proc_read(AW'(a), "R12");

    // R10: output enable acts without a clock edge
    proc_read(AW'(3), "R10");
    idle(); tick("R10");
    oe_n = 1; #1;
    chk("R10 oe high", {31'd0, dout_en}, 32'd0);
    oe_n = 0; #1;
    chk("R10 oe low", {31'd0, dout_en}, 32'd1);
    chk("R10 data", dout, ref_mem[3]);
    idle(); oe_n = 1; tick("R10");
    idle(); oe_n = 1; tick("R10");
    deselect("R11");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule